// File: doc/BRIEF.md
# Clock-Crossing Peripheral Control Register

This block is the control register of a peripheral whose working logic runs on its own core clock, unrelated to the bus clock that software uses. Software reaches it through a simple bus port: an address, write data, a write strobe, a read strobe and registered read data, plus a one-cycle error strobe for refused accesses. The register holds three fields. The first is a core clock source choice, exported as a plain level. The second is an enable. The third is a software reset.

Enable and reset requests are carried into the core domain over toggle handshakes. Each has a busy flag that software can read. A reset write takes precedence over the other fields written with it. It clears the register at once and then runs a small state machine. `ST_IDLE` moves to `ST_RST_DRAIN` on a reset write. `ST_RST_DRAIN` moves to `ST_RST_XFER` once no enable transfer is pending. `ST_RST_XFER` issues the reset request and moves to `ST_RST_WAIT` after one cycle. `ST_RST_WAIT` returns to `ST_IDLE` when the reset acknowledge has come back. Any state other than `ST_IDLE` counts as reset-busy, and register access is restricted while it lasts.

Top module: `periph_ctl_sync`

## Requirements
- R1: After reset, the control word (offset 0x0) and the busy word (offset 0x4) read 0, and `clk_sel_o` and `core_enable` are 0.
- R2: Bit 4 of the control word is the clock choice: 0 selects the fast clock and 1 selects the 32.768 kHz low-power clock. While the enable is 0, a written value appears on `clk_sel_o` and reads back right away.
- R3: While the enable bit is 1, writes to bit 4 are ignored.
- R4: Bit 1 of the control word is the enable. An accepted written value reads back on the next read.
- R5: An accepted enable write sets bit 1 of the busy word. That bit clears only after `core_enable` already equals the written value.
- R6: An enable write that arrives while bit 1 of the busy word is 1 is dropped. The previous enable value stays in place.
- R7: Writing 0 to bit 0 of the control word starts no reset. Writing 1 clears every field at once. When the reset completes, `core_enable` is 0 and `core_srst` has pulsed once.
- R8: When bit 0 is written as 1, the clock and enable bits of that same write are discarded.
- R9: While a reset runs, bit 0 of both the control word and the busy word read 1. Every write is refused, and reads of unmapped addresses are refused and return 0.
- R10: A refused access raises `bus_err` for one cycle. Reads of the control and busy words during reset are not refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus-domain reset, active low |
| core_clk | input | 1 | Core clock |
| core_rst_n | input | 1 | Core-domain reset, active low |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, valid the cycle after the read strobe |
| bus_err | output | 1 | Refused-access strobe |
| clk_sel_o | output | 1 | Core clock source choice |
| core_enable | output | 1 | Enable as applied in the core domain |
| core_srst | output | 1 | One-cycle core-domain reset pulse |

## Verification
Random control words, with each write followed by a wait for idle, test the readback path and the enable crossing against a bench model. They show whether protection is judged on the old or the new enable value. Back-to-back enable writes tell a dropped write apart from a queued one. A reset write carrying set enable and clock bits shows whether precedence holds. A reset issued behind a pending enable transfer shows whether the two requests reach the core domain in order. Writes and unmapped reads during reset tell refusal apart from normal access.

// File: rtl/pcs_pkg.sv
`timescale 1ns/1ps
package pcs_pkg;
    localparam int CTRL_OFS = 0;
    localparam int BUSY_OFS = 4;
    localparam int SRST_BIT = 0;
    localparam int EN_BIT   = 1;
    localparam int SEL_BIT  = 4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RST_DRAIN,
        ST_RST_XFER,
        ST_RST_WAIT
    } rst_state_e;
endpackage

// File: rtl/pcs_sync2.sv
`timescale 1ns/1ps
module pcs_sync2 #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/pcs_xfer.sv
`timescale 1ns/1ps
module pcs_xfer #(
    parameter int W = 1,
    parameter int STAGES = 2
) (
    input  logic         src_clk,
    input  logic         src_rst_n,
    input  logic         start,
    input  logic [W-1:0] din,
    output logic         busy,
    input  logic         dst_clk,
    input  logic         dst_rst_n,
    output logic         apply,
    output logic [W-1:0] dout
);
    logic         req_tgl;
    logic [W-1:0] data_q;
    logic         ack_s;
    logic         req_s;
    logic         seen_q;

    // source side: toggle request, hold data until acknowledged
    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) begin
            req_tgl <= 1'b0;
            data_q  <= '0;
        end else if (start) begin
            req_tgl <= ~req_tgl;
            data_q  <= din;
        end
    end

    pcs_sync2 #(.STAGES(STAGES)) u_ack_sync (
        .clk(src_clk), .rst_n(src_rst_n), .d(seen_q), .q(ack_s)
    );

    assign busy = req_tgl ^ ack_s;

    // destination side: detect a toggle, apply once, echo as acknowledge
    pcs_sync2 #(.STAGES(STAGES)) u_req_sync (
        .clk(dst_clk), .rst_n(dst_rst_n), .d(req_tgl), .q(req_s)
    );

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) seen_q <= 1'b0;
        else            seen_q <= req_s;
    end

    assign apply = req_s ^ seen_q;
    assign dout  = data_q;

    // R6: a new request is issued only when the previous one has returned
    p_start_free_r6: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        start |-> !busy);

    // R5: each request is applied in exactly one destination cycle
    p_apply_once_r5: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
        apply |=> !apply);
endmodule

// File: rtl/pcs_bus_regs.sv
`timescale 1ns/1ps
module pcs_bus_regs
    import pcs_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    output logic              err,
    output logic              clk_sel,
    output logic              en_start,
    output logic              en_data,
    input  logic              en_busy,
    output logic              srst_start,
    input  logic              srst_ch_busy
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] A_BUSY = ADDR_W'(BUSY_OFS);

    rst_state_e state, state_nx;
    logic en_q, sel_q;
    logic ctrl_hit, busy_hit, srst_busy, wr_ctrl, swrst_req, refuse;
    logic [DATA_W-1:0] ctrl_word, busy_word;

    assign ctrl_hit  = (addr == A_CTRL);
    assign busy_hit  = (addr == A_BUSY);
    assign srst_busy = (state != ST_IDLE);
    assign wr_ctrl   = wr_en && ctrl_hit && !srst_busy;
    assign swrst_req = wr_ctrl && wdata[SRST_BIT];
    assign refuse    = srst_busy && (wr_en || (rd_en && !ctrl_hit && !busy_hit));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (swrst_req)     state_nx = ST_RST_DRAIN;
            ST_RST_DRAIN: if (!en_busy)      state_nx = ST_RST_XFER;
            ST_RST_XFER:                     state_nx = ST_RST_WAIT;
            ST_RST_WAIT:  if (!srst_ch_busy) state_nx = ST_IDLE;
        endcase
    end

    // outputs towards the crossings
    always_comb begin
        srst_start = (state == ST_RST_XFER);
        en_start   = wr_ctrl && !wdata[SRST_BIT] && !en_busy;
        en_data    = wdata[EN_BIT];
    end

    // fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= 1'b0;
        end else if (swrst_req) begin
            en_q  <= 1'b0;
            sel_q <= 1'b0;
        end else if (wr_ctrl) begin
            if (en_start) en_q  <= wdata[EN_BIT];
            if (!en_q)    sel_q <= wdata[SEL_BIT];
        end
    end

    always_comb begin
        ctrl_word = '0;
        ctrl_word[SEL_BIT]  = sel_q;
        ctrl_word[EN_BIT]   = en_q;
        ctrl_word[SRST_BIT] = srst_busy;
        busy_word = '0;
        busy_word[EN_BIT]   = en_busy;
        busy_word[SRST_BIT] = srst_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
            err   <= 1'b0;
        end else begin
            err <= refuse;
            if (rd_en) begin
                if (refuse)        rdata <= '0;
                else if (ctrl_hit) rdata <= ctrl_word;
                else if (busy_hit) rdata <= busy_word;
                else               rdata <= '0;
            end
        end
    end

    assign clk_sel = sel_q;

    logic unused_wd;
    assign unused_wd = ^wdata;

    // R3: clock choice frozen while enabled, except by a reset
    p_sel_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |=> ($stable(sel_q) || srst_busy));
    // R6: enable unchanged while its transfer is pending, except by a reset
    p_en_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en_busy |=> ($stable(en_q) || srst_busy));
    // R7 / R8: a reset write clears all fields and enters the drain state
    p_swrst_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_req |=> (!en_q && !sel_q && state == ST_RST_DRAIN));
    // R7: the reset request leaves only with no enable transfer in flight
    p_rst_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RST_XFER) |-> !en_busy);
    // R10: an error strobe only follows a cycle spent in reset
    p_err_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(srst_busy));
endmodule

// File: rtl/periph_ctl_sync.sv
`timescale 1ns/1ps
module periph_ctl_sync #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              core_clk,
    input  logic              core_rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              clk_sel_o,
    output logic              core_enable,
    output logic              core_srst
);
    logic en_start, en_data, en_busy, en_apply, en_val;
    logic srst_start, srst_busy, srst_apply, srst_val;

    pcs_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(bus_clk), .rst_n(bus_rst_n),
        .addr(bus_addr), .wdata(bus_wdata), .wr_en(bus_wr), .rd_en(bus_rd),
        .rdata(bus_rdata), .err(bus_err), .clk_sel(clk_sel_o),
        .en_start(en_start), .en_data(en_data), .en_busy(en_busy),
        .srst_start(srst_start), .srst_ch_busy(srst_busy)
    );

    pcs_xfer #(.W(1), .STAGES(SYNC_STAGES)) u_en_xfer (
        .src_clk(bus_clk), .src_rst_n(bus_rst_n),
        .start(en_start), .din(en_data), .busy(en_busy),
        .dst_clk(core_clk), .dst_rst_n(core_rst_n),
        .apply(en_apply), .dout(en_val)
    );

    pcs_xfer #(.W(1), .STAGES(SYNC_STAGES)) u_srst_xfer (
        .src_clk(bus_clk), .src_rst_n(bus_rst_n),
        .start(srst_start), .din(1'b1), .busy(srst_busy),
        .dst_clk(core_clk), .dst_rst_n(core_rst_n),
        .apply(srst_apply), .dout(srst_val)
    );

    always_ff @(posedge core_clk or negedge core_rst_n) begin
        if (!core_rst_n) begin
            core_enable <= 1'b0;
            core_srst   <= 1'b0;
        end else begin
            core_srst <= srst_apply && srst_val;
            if (srst_apply)    core_enable <= 1'b0;
            else if (en_apply) core_enable <= en_val;
        end
    end

    // R7: the core reset pulse leaves the peripheral disabled
    p_core_rst_off_r7: assert property (@(posedge core_clk) disable iff (!core_rst_n)
        core_srst |-> !core_enable);
endmodule

// File: tb/periph_ctl_sync_tb.sv
`timescale 1ns/1ps
module periph_ctl_sync_tb;
    logic bclk = 0, cclk = 0, brst_n = 0, crst_n = 0;
    logic [3:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic wr = 0, rd = 0;
    logic [31:0] rdata;
    logic err, clk_sel, core_en, core_srst;

    int errors = 0, checks = 0, cyc = 0, srst_cnt = 0;

    always #4 bclk = ~bclk;
    always #18.5 cclk = ~cclk;

    periph_ctl_sync u_dut (
        .bus_clk(bclk), .bus_rst_n(brst_n), .core_clk(cclk), .core_rst_n(crst_n),
        .bus_addr(addr), .bus_wdata(wdata), .bus_wr(wr), .bus_rd(rd),
        .bus_rdata(rdata), .bus_err(err), .clk_sel_o(clk_sel),
        .core_enable(core_en), .core_srst(core_srst)
    );

    always @(posedge cclk) if (core_srst) srst_cnt++;

    always @(posedge bclk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d, output logic e);
        @(negedge bclk); addr = a; wdata = d; wr = 1;
        @(negedge bclk); wr = 0; e = err;
    endtask

    task automatic do_read(input logic [3:0] a, output logic [31:0] d, output logic e);
        @(negedge bclk); addr = a; rd = 1;
        @(negedge bclk); rd = 0; d = rdata; e = err;
    endtask

    task automatic wait_idle(output int n);
        logic [31:0] d; logic e;
        n = 0;
        do begin do_read(4'h4, d, e); n++; end while (d[1:0] != 0 && n < 300);
    endtask

    function automatic logic [1:0] model(input logic en, input logic sel, input logic [31:0] d);
        if (d[0]) return 2'b00;
        return {(en ? sel : d[4]), d[1]};
    endfunction

    initial begin
        logic [31:0] d; logic e; int n, s0;
        logic exp_en, exp_sel; logic [1:0] m;
        d = $urandom(32'd1234);
        exp_en = 0; exp_sel = 0;
        repeat (5) @(negedge bclk);
        brst_n = 1; crst_n = 1;
        repeat (3) @(negedge bclk);

        // R1 reset state
        do_read(4'h0, d, e); check(d == 0, "R1 ctrl", d, 0);
        do_read(4'h4, d, e); check(d == 0, "R1 busy", d, 0);
        check(clk_sel == 0 && core_en == 0, "R1 outputs", {clk_sel, core_en}, 0);

        // R2 clock choice while disabled
        do_write(4'h0, 32'h10, e);
        check(clk_sel == 1, "R2 sel set", clk_sel, 1);
        do_read(4'h0, d, e); check(d == 32'h10, "R2 readback", d, 32'h10);
        do_write(4'h0, 32'h00, e); wait_idle(n);
        check(clk_sel == 0, "R2 sel clear", clk_sel, 0);

        // R4/R5 enable with busy timing
        do_write(4'h0, 32'h12, e);
        do_read(4'h4, d, e); check(d[1] == 1, "R5 busy set", d, 2);
        check(core_en == 0, "R5 core not yet", core_en, 0);
        do_read(4'h0, d, e); check(d == 32'h12, "R4 readback", d, 32'h12);
        wait_idle(n);
        check(core_en == 1, "R5 core applied", core_en, 1);
        check(n < 40, "R5 busy bound", n, 40);

        // R3 lock while enabled; R7 zero in bit 0 starts no reset
        do_write(4'h0, 32'h02, e);
        do_read(4'h4, d, e); check(d[0] == 0, "R7 no reset on 0", d, 0);
        wait_idle(n);
        check(clk_sel == 1, "R3 sel locked", clk_sel, 1);
        do_read(4'h0, d, e); check(d == 32'h12, "R3 readback", d, 32'h12);

        // R6 second enable write while busy dropped
        do_write(4'h0, 32'h00, e);
        do_write(4'h0, 32'h02, e);
        do_read(4'h0, d, e); check(d[1] == 0, "R6 dropped", d, 0);
        wait_idle(n);
        check(core_en == 0, "R6 core value", core_en, 0);
        do_write(4'h0, 32'h12, e); wait_idle(n);

        // R8/R9/R10 reset precedence and blocking
        s0 = srst_cnt;
        do_write(4'h0, 32'h13, e);
        do_read(4'h0, d, e);
        check(d == 32'h01, "R8 fields discarded", d, 1);
        check(e == 0, "R10 ctrl read allowed", e, 0);
        do_read(4'h4, d, e); check(d[0] == 1, "R9 busy bit", d, 1);
        do_write(4'h0, 32'h12, e); check(e == 1, "R10 write refused", e, 1);
        do_read(4'h8, d, e);
        check(d == 0 && e == 1, "R9 unmapped refused", {d[30:0], e}, 1);
        do_read(4'h0, d, e); check(d == 32'h01, "R9 write had no effect", d, 1);
        wait_idle(n);
        do_read(4'h0, d, e); check(d == 0, "R7 cleared", d, 0);
        check(core_en == 0 && clk_sel == 0, "R7 outputs", {clk_sel, core_en}, 0);
        check(srst_cnt == s0 + 1, "R7 pulse", srst_cnt, s0 + 1);

        // R7 reset behind a pending enable transfer
        s0 = srst_cnt;
        do_write(4'h0, 32'h02, e);
        do_write(4'h0, 32'h01, e);
        wait_idle(n);
        check(core_en == 0, "R7 order core", core_en, 0);
        check(srst_cnt == s0 + 1, "R7 order pulse", srst_cnt, s0 + 1);
        exp_en = 0; exp_sel = 0;

        // random stimulus
        for (int i = 0; i < 60; i++) begin
            logic [31:0] r;
            r = $urandom;
            if ((r[31:29]) != 0) r[0] = 0;
            s0 = srst_cnt;
            m = model(exp_en, exp_sel, r);
            do_write(4'h0, r, e);
            exp_sel = m[1]; exp_en = m[0];
            wait_idle(n);
            do_read(4'h0, d, e);
            check(d == {27'd0, exp_sel, 2'b00, exp_en, 1'b0}, "R2 R3 R4 R8 random ctrl", d,
                  {27'd0, exp_sel, 2'b00, exp_en, 1'b0});
            check(core_en == exp_en && clk_sel == exp_sel, "R5 random outputs",
                  {clk_sel, core_en}, {exp_sel, exp_en});
            if (r[0]) check(srst_cnt == s0 + 1, "R7 random pulse", srst_cnt, s0 + 1);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule